// File: doc/BRIEF.md
# Triple Watchdog Timer Peripheral

This peripheral holds three independent 16-bit countdown watchdogs behind a small synchronous register bus. Each watchdog counts down once per tick from a value loaded through its limit register. When it runs out it takes an action that depends on which watchdog it is. Watchdog 0 raises a level interrupt request. Watchdog 1 pulses a CPU reset output. Watchdog 2 pulses a full system reset output. A tick prescaler divides the system clock down to the nominal tenth-of-a-second count rate.

Software starts a watchdog by writing its limit register. It keeps the watchdog alive by reading the counter register, and that read reloads the count from the limit. A shared mask register can silence any watchdog's action. A masked watchdog still counts, still expires and still shows its status. Bus reads return data one cycle after the request. Each register answers only to its own access width, byte or halfword.

Top module: `triwdog_top`

## Requirements
- R1: After reset every counter and every limit register reads 1, every status register reads 0, the mask register reads 0 and all three action outputs are low.
- R2: Watchdog n owns bytes 16*n to 16*n+15. In each window the counter is at offset 0x0, the limit at 0x4 and the status at 0x8. The mask register is at byte 48. Every other address reads 0. Read data appears on the cycle after the read request.
- R3: Counter and limit registers accept only halfword accesses (half=1), and status and mask registers accept only byte accesses (half=0). An access of the wrong width writes nothing, reads 0 and has no side effect.
- R4: A halfword write to a limit register stores the value, loads it into the counter, sets the running bit and clears the expired bit. A watchdog that is not running keeps its count.
- R5: A running watchdog decrements once per tick, and a tick occurs every TICK_DIV clocks. On the tick that brings the count to zero (or a tick while the count is already zero) the count becomes 0 and the status becomes 0x02, meaning expired set and running clear. Status bit 0 is running, bit 1 is expired, and the other bits read 0.
- R6: A halfword read of a running watchdog's counter returns the current count and reloads the counter from the limit, and this reload takes priority over a tick in the same cycle. Reading the counter of a stopped or expired watchdog, or reading any limit register, changes nothing.
- R7: The expired bit stays set, and the count stays 0, until the next limit write.
- R8: Mask bit n (n = 0, 1, 2) belongs to watchdog n, and a 1 disables that watchdog's action. Bits 7 to 3 read 0 and ignore writes.
- R9: wd_irq is high exactly while watchdog 0 is expired and mask bit 0 is clear.
- R10: cpu_rst (watchdog 1) and sys_rst (watchdog 2) go high for exactly RST_PULSE clocks, starting on the cycle the expired bit first reads set. A pulse is produced only if the mask bit was clear when the expiry happened. Clearing the mask later produces no pulse.
- R11: A masked watchdog keeps counting and expires on schedule, and its status reports this.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_half | input | 1 | 1 = halfword access, 0 = byte access |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after a read |
| wd_irq | output | 1 | Interrupt request level from watchdog 0 |
| cpu_rst | output | 1 | CPU reset pulse from watchdog 1 |
| sys_rst | output | 1 | System reset pulse from watchdog 2 |

## Verification
The bench aims at the side effect of reading the counter. A design that reloaded on every read would restart an expired watchdog or clear its expired bit, so the bench reads the counter of an expired watchdog twice and expects 0 both times. It also checks the width filter: a byte write to a limit register must not start the watchdog. Masking gets its own tests. The bench checks that a masked watchdog 1 expires without pulsing cpu_rst, and that clearing the mask afterwards does not release a late pulse. It checks that the interrupt level follows the mask in both directions while watchdog 0 stays expired. Finally it measures the width of the system reset pulse and confirms that a limit of 0 expires on the first tick.

// File: rtl/triwdog_pkg.sv
// Shared constants and types for the triple watchdog peripheral.
package triwdog_pkg;
    localparam int NUM_WD   = 3;     // watchdog count, fixed by the three action roles
    localparam int CNT_W    = 16;    // counter and limit width
    localparam int ADDR_W   = 6;     // byte address width
    localparam int DATA_W   = 16;    // bus data width

    // Register selected inside one watchdog window
    typedef enum logic [1:0] {
        SEL_COUNT  = 2'd0,
        SEL_LIMIT  = 2'd1,
        SEL_STATUS = 2'd2,
        SEL_NONE   = 2'd3
    } wd_reg_e;

    // Offsets inside a window; these are decoded by software, so they stay fixed
    localparam logic [3:0] OFS_COUNT  = 4'h0;
    localparam logic [3:0] OFS_LIMIT  = 4'h4;
    localparam logic [3:0] OFS_STATUS = 4'h8;
    localparam logic [1:0] CTRL_WIN   = 2'd3;
endpackage

// File: rtl/twd_tick_gen.sv
// Tick prescaler: emits a one-cycle tick every DIV clocks.
// Assumes DIV >= 1; the count runs freely from reset.
module twd_tick_gen #(
    parameter int DIV = 10_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

    logic [W-1:0] div_q;

    assign tick = (div_q == W'(DIV - 1));

    // Wrapping divider counter
    always_ff @(posedge clk) begin
        if (!rst_n)     div_q <= '0;
        else if (tick)  div_q <= '0;
        else            div_q <= div_q + 1'b1;
    end
endmodule

// File: rtl/twd_channel.sv
// One countdown watchdog: holds count, limit, running and expired state.
// A load (limit write) starts it; a kick (counter read) reloads it while running.
// Assumes load and kick never arrive in the same cycle (one bus access per cycle).
module twd_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             kick,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] limit,
    output logic             running,
    output logic             expired,
    output logic             expire_evt
);
    // Expiry happens on a tick that would take the count to zero (or is already zero)
    always_comb begin
        expire_evt = running && tick && !kick && (count <= CNT_W'(1));
    end

    // Count, limit and state update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count   <= CNT_W'(1);
            limit   <= CNT_W'(1);
            running <= 1'b0;
            expired <= 1'b0;
        end else if (load) begin
            count   <= load_val;
            limit   <= load_val;
            running <= 1'b1;
            expired <= 1'b0;
        end else if (kick && running) begin
            count   <= limit;
        end else if (expire_evt) begin
            count   <= '0;
            running <= 1'b0;
            expired <= 1'b1;
        end else if (running && tick) begin
            count   <= count - 1'b1;
        end
    end
endmodule

// File: rtl/twd_pulse.sv
// Pulse stretcher: a trigger yields an output high for exactly PULSE cycles,
// starting the cycle after the trigger. Assumes PULSE >= 1.
module twd_pulse #(
    parameter int PULSE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic pulse
);
    localparam int PW = $clog2(PULSE + 1);

    logic [PW-1:0] left_q;

    assign pulse = (left_q != '0);

    // Remaining-cycles counter
    always_ff @(posedge clk) begin
        if (!rst_n)             left_q <= '0;
        else if (trig)          left_q <= PW'(PULSE);
        else if (left_q != '0)  left_q <= left_q - 1'b1;
    end
endmodule

// File: rtl/triwdog_top.sv
// Triple watchdog peripheral: register decode, mask register, three channels
// and their actions (interrupt level for 0, reset pulses for 1 and 2).
// Assumes one bus access per cycle; reads return data one cycle later.
module triwdog_top
    import triwdog_pkg::*;
#(
    parameter int TICK_DIV  = 10_000_000,
    parameter int RST_PULSE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic              bus_half,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wd_irq,
    output logic              cpu_rst,
    output logic              sys_rst
);
    logic [1:0]          win;
    logic [3:0]          ofs;
    wd_reg_e             reg_sel;
    logic                tick;
    logic [NUM_WD-1:0]   mask_q;
    logic [NUM_WD-1:0]   run_v;
    logic [NUM_WD-1:0]   exp_v;
    logic [NUM_WD-1:0]   evt_v;
    logic [NUM_WD-1:0]   lim_wr;
    logic [NUM_WD-1:0]   kick;
    logic [NUM_WD-1:0]   act_pulse;
    logic [CNT_W-1:0]    cnt_a [NUM_WD];
    logic [CNT_W-1:0]    lim_a [NUM_WD];
    logic [NUM_WD*CNT_W-1:0] cnt_flat;
    logic                mask_wr;
    logic [DATA_W-1:0]   rd_val;

    assign win = bus_addr[5:4];
    assign ofs = bus_addr[3:0];

    // Register select inside a watchdog window, width-qualified
    always_comb begin
        reg_sel = SEL_NONE;
        if (ofs == OFS_COUNT && bus_half)        reg_sel = SEL_COUNT;
        else if (ofs == OFS_LIMIT && bus_half)   reg_sel = SEL_LIMIT;
        else if (ofs == OFS_STATUS && !bus_half) reg_sel = SEL_STATUS;
    end

    assign mask_wr = bus_sel && bus_we && !bus_half && (win == CTRL_WIN) && (ofs == 4'h0);

    twd_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    genvar gi;
    generate
        for (gi = 0; gi < NUM_WD; gi++) begin : g_wd
            assign lim_wr[gi] = bus_sel && bus_we && (win == 2'(gi)) && (reg_sel == SEL_LIMIT);
            assign kick[gi]   = bus_sel && !bus_we && (win == 2'(gi)) && (reg_sel == SEL_COUNT);

            twd_channel #(.CNT_W(CNT_W)) u_chan (
                .clk        (clk),
                .rst_n      (rst_n),
                .tick       (tick),
                .load       (lim_wr[gi]),
                .load_val   (bus_wdata[CNT_W-1:0]),
                .kick       (kick[gi]),
                .count      (cnt_a[gi]),
                .limit      (lim_a[gi]),
                .running    (run_v[gi]),
                .expired    (exp_v[gi]),
                .expire_evt (evt_v[gi])
            );

            assign cnt_flat[gi*CNT_W +: CNT_W] = cnt_a[gi];

            if (gi == 0) begin : g_level
                // Watchdog 0 acts through a level, not a pulse
                assign act_pulse[gi] = 1'b0;
            end else begin : g_pulse
                twd_pulse #(.PULSE(RST_PULSE)) u_pulse (
                    .clk   (clk),
                    .rst_n (rst_n),
                    .trig  (evt_v[gi] && !mask_q[gi]),
                    .pulse (act_pulse[gi])
                );
            end
        end
    endgenerate

    // Shared action mask register
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_wr) mask_q <= bus_wdata[NUM_WD-1:0];
    end

    // Read multiplexer over all windows
    always_comb begin
        rd_val = '0;
        if (win == CTRL_WIN) begin
            if (ofs == 4'h0 && !bus_half) rd_val = DATA_W'(mask_q);
        end else begin
            for (int i = 0; i < NUM_WD; i++) begin
                if (win == 2'(i)) begin
                    case (reg_sel)
                        SEL_COUNT:  rd_val = DATA_W'(cnt_a[i]);
                        SEL_LIMIT:  rd_val = DATA_W'(lim_a[i]);
                        SEL_STATUS: rd_val = DATA_W'({exp_v[i], run_v[i]});
                        default:    rd_val = '0;
                    endcase
                end
            end
        end
    end

    // Registered read data, one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n)                  bus_rdata <= '0;
        else if (bus_sel && !bus_we) bus_rdata <= rd_val;
        else                         bus_rdata <= '0;
    end

    assign wd_irq  = exp_v[0] && !mask_q[0];
    assign cpu_rst = act_pulse[1];
    assign sys_rst = act_pulse[2];
endmodule

// File: rtl/triwdog_checker.sv
// Property checker for the triple watchdog; attached to the top by bind.
module triwdog_checker #(
    parameter int NW = 3,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NW-1:0] mask_q,
    input logic [NW-1:0] run_v,
    input logic [NW-1:0] exp_v,
    input logic [NW-1:0] lim_wr,
    input logic [NW*CW-1:0] cnt_flat,
    input logic          wd_irq,
    input logic          cpu_rst,
    input logic          sys_rst
);
    genvar gi;
    generate
        for (gi = 0; gi < NW; gi++) begin : g_chk
            assert_stopped_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (!run_v[gi] && !lim_wr[gi]) |=> $stable(cnt_flat[gi*CW +: CW]));
            assert_run_exp_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
                !(run_v[gi] && exp_v[gi]));
            assert_exp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (exp_v[gi] && !lim_wr[gi]) |=> exp_v[gi]);
        end
    endgenerate

    assert_irq_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_v[0] && !mask_q[0]) |-> wd_irq);
    assert_irq_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !exp_v[0] |-> !wd_irq);
    assert_cpu_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(exp_v[1]) && !$past(mask_q[1])) |-> cpu_rst);
    assert_sys_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(exp_v[2]) && !$past(mask_q[2])) |-> sys_rst);
endmodule

bind triwdog_top triwdog_checker #(.NW(3), .CW(16)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mask_q   (mask_q),
    .run_v    (run_v),
    .exp_v    (exp_v),
    .lim_wr   (lim_wr),
    .cnt_flat (cnt_flat),
    .wd_irq   (wd_irq),
    .cpu_rst  (cpu_rst),
    .sys_rst  (sys_rst)
);

// File: tb/triwdog_top_tb.sv
`timescale 1ns/1ps
module triwdog_top_tb;
    localparam int DIV   = 4;
    localparam int PULSE = 5;
    localparam int NVEC  = 13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0, bus_half = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        wd_irq, cpu_rst, sys_rst;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    triwdog_top #(.TICK_DIV(DIV), .RST_PULSE(PULSE)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_half(bus_half), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .wd_irq(wd_irq), .cpu_rst(cpu_rst), .sys_rst(sys_rst)
    );

    // Vector: {we, half, addr[5:0], wdata[15:0], expect[15:0]}
    localparam logic [39:0] VEC [NVEC] = '{
        {1'b0, 1'b1, 6'h00, 16'h0000, 16'h0001},  // R1 ch0 count
        {1'b0, 1'b1, 6'h14, 16'h0000, 16'h0001},  // R1 ch1 limit
        {1'b0, 1'b0, 6'h28, 16'h0000, 16'h0000},  // R1 ch2 status
        {1'b0, 1'b0, 6'h30, 16'h0000, 16'h0000},  // R1 mask
        {1'b1, 1'b0, 6'h30, 16'h00FF, 16'h0000},  // R8 mask write
        {1'b0, 1'b0, 6'h30, 16'h0000, 16'h0007},  // R8 upper bits zero
        {1'b1, 1'b0, 6'h30, 16'h0000, 16'h0000},  // R8 mask clear
        {1'b0, 1'b1, 6'h0C, 16'h0000, 16'h0000},  // R2 unused offset
        {1'b0, 1'b0, 6'h10, 16'h0000, 16'h0000},  // R3 byte read of counter
        {1'b1, 1'b0, 6'h24, 16'h0055, 16'h0000},  // R3 byte write of limit
        {1'b0, 1'b1, 6'h24, 16'h0000, 16'h0001},  // R3 limit unchanged
        {1'b0, 1'b0, 6'h28, 16'h0000, 16'h0000},  // R3 not started
        {1'b0, 1'b1, 6'h34, 16'h0000, 16'h0000}   // R2 unused control offset
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [5:0] a, input logic half, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_half = half; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [5:0] a, input logic half, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_half = half; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog on the run itself
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        int cpu_hi, sys_hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 outputs after reset
        @(negedge clk);
        chk("R1 outputs", {13'b0, wd_irq, cpu_rst, sys_rst}, 16'h0);

        // Vector table walk (R1 R2 R3 R8)
        for (int v = 0; v < NVEC; v++) begin
            if (VEC[v][39]) begin
                bus_wr(VEC[v][37:32], VEC[v][38], VEC[v][31:16]);
            end else begin
                bus_rd(VEC[v][37:32], VEC[v][38], rd);
                chk($sformatf("R1/R2/R3/R8 vector %0d", v), rd, VEC[v][15:0]);
            end
        end

        // R4: a stopped watchdog holds its count
        idle(20);
        bus_rd(6'h00, 1'b1, rd);
        chk("R4 stopped count holds", rd, 16'h0001);

        // R4/R5: start ch0 with limit 3, then let it expire
        bus_wr(6'h04, 1'b1, 16'd3);
        bus_rd(6'h08, 1'b0, rd);
        chk("R4 running after limit write", rd, 16'h0001);
        idle(3 * DIV + 4);
        bus_rd(6'h08, 1'b0, rd);
        chk("R5 expired status", rd, 16'h0002);
        chk("R9 irq on expiry", {15'b0, wd_irq}, 16'h1);
        bus_rd(6'h00, 1'b1, rd);
        chk("R5 count zero", rd, 16'h0000);
        bus_rd(6'h00, 1'b1, rd);
        chk("R6 no reload when expired", rd, 16'h0000);
        idle(3 * DIV);
        bus_rd(6'h08, 1'b0, rd);
        chk("R7 expired persists", rd, 16'h0002);

        // R9: mask follows in both directions
        bus_wr(6'h30, 1'b0, 16'h0001);
        @(negedge clk);
        chk("R9 irq masked", {15'b0, wd_irq}, 16'h0);
        bus_rd(6'h08, 1'b0, rd);
        chk("R11 masked still reports", rd, 16'h0002);
        bus_wr(6'h30, 1'b0, 16'h0000);
        @(negedge clk);
        chk("R9 irq unmasked", {15'b0, wd_irq}, 16'h1);

        // R7: limit write clears expired
        bus_wr(6'h04, 1'b1, 16'd5);
        chk("R7 irq clear after restart", {15'b0, wd_irq}, 16'h0);
        bus_rd(6'h08, 1'b0, rd);
        chk("R7 running after restart", rd, 16'h0001);

        // R6: periodic kicks keep ch0 alive
        for (int k = 0; k < 10; k++) begin
            idle(2 * DIV);
            bus_rd(6'h00, 1'b1, rd);
        end
        bus_rd(6'h08, 1'b0, rd);
        chk("R6 kicked watchdog still running", rd, 16'h0001);
        bus_rd(6'h00, 1'b1, rd);
        bus_rd(6'h00, 1'b1, rd);
        chk("R6 count reloaded", {15'b0, (rd == 16'd5 || rd == 16'd4)}, 16'h1);
        bus_rd(6'h04, 1'b1, rd);
        chk("R6 limit read", rd, 16'd5);

        // R10/R11: ch1 masked, ch2 unmasked; ch0 masked too
        bus_wr(6'h30, 1'b0, 16'h0003);
        bus_wr(6'h14, 1'b1, 16'd2);
        bus_wr(6'h24, 1'b1, 16'd2);
        cpu_hi = 0; sys_hi = 0;
        for (int c = 0; c < 3 * DIV + PULSE + 10; c++) begin
            @(negedge clk);
            if (cpu_rst) cpu_hi++;
            if (sys_hi >= 0 && sys_rst) sys_hi++;
        end
        chk("R10 masked cpu reset silent", 16'(cpu_hi), 16'd0);
        chk("R10 sys reset pulse width", 16'(sys_hi), 16'(PULSE));
        bus_rd(6'h18, 1'b0, rd);
        chk("R11 masked ch1 expired", rd, 16'h0002);
        bus_rd(6'h28, 1'b0, rd);
        chk("R5 ch2 expired", rd, 16'h0002);

        // R10: unmasking after expiry releases no pulse
        bus_wr(6'h30, 1'b0, 16'h0001);
        cpu_hi = 0;
        for (int c = 0; c < PULSE + 4; c++) begin
            @(negedge clk);
            if (cpu_rst) cpu_hi++;
        end
        chk("R10 no late pulse", 16'(cpu_hi), 16'd0);

        // R5: limit 0 expires on the first tick
        bus_wr(6'h24, 1'b1, 16'd0);
        idle(DIV + 2);
        bus_rd(6'h28, 1'b0, rd);
        chk("R5 zero limit expires", rd, 16'h0002);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule